// File: doc/BRIEF.md
# Scrolled Layer Compositor with Collision Capture

This block merges two 3-bit pixel layers into a 6-bit palette index for each position of a 256x256 raster. The background layer is scrolled: for every raster position the block emits wrapped fetch coordinates, and the tile logic outside it returns the background pixel at that spot in the same cycle. The foreground pixel comes straight from a bitmap layer. The block places the foreground value above the background value in the output index.

While it composes, the block checks whether the two layers overlap. An overlap counts when the foreground pixel is nonzero and the background pixel has a set bit under a collision mask. A control input narrows that mask to the top background bit only. The block acts on at most a fixed number of overlaps per frame. Each overlap it acts on latches the raster position and raises a pending flag. The block also holds a foreground-collision flag reported by a drawing engine, and a vblank flag. It combines the three flags into one interrupt line, which a host services through a small read port. Some reads of that port clear the flags.

Top module: `layer_mixer`

## Requirements
- R1: The background fetch coordinates are bg_x = (raster_x + scroll_x) mod 256 and bg_y = (raster_y[7:0] + scroll_y) mod 256. Both are combinational from the current inputs.
- R2: On a cycle with pix_valid high, the block registers color_idx as {fg_pix, bg_pix}: foreground in bits 5:3 and background in bits 2:0. The new value appears after that clock edge. color_idx is 0 after reset.
- R3: A background collision is detected on a pix_valid cycle when fg_pix is nonzero and (bg_pix AND mask) is nonzero. The mask is 3'b100 when narrow_mask is 1 and 3'b111 when it is 0.
- R4: A collision that is acted on latches raster_x as the collision X and raster_y[7:0] as the collision Y, and sets the background-collision pending flag. At most COLL_CAP (default 128) collisions are acted on per frame. Later ones change neither the latch nor the flag. frame_start resets the count.
- R5: irq is high exactly when at least one of these holds: vblank is pending, a foreground collision is pending, or a background collision is pending while bg_irq_en is 1.
- R6: A read with rd_sel=3 clears the background-collision pending flag, and a read with rd_sel=1 clears the foreground-collision pending flag. clr_vblank clears the vblank flag. If a set and a clear arrive in the same cycle, the set wins.
- R7: rd_data is combinational from rd_sel. Codes 0 and 1 return the foreground collision X and Y. Code 2 returns the background collision X with bits 1:0 forced to 0. Code 3 returns the background collision Y. Codes 5 to 7 return 0.
- R8: A read with rd_sel=4 returns the status byte. Bit 7 is busy, bit 6 is NOT fg-pending, bit 5 is NOT vblank-pending, bit 4 is NOT bg-pending, bit 3 is raster_y[8], and bits 2:0 are 0.
- R9: fg_coll_set sets the foreground-collision pending flag and latches fg_coll_x and fg_coll_y for the reads with rd_sel 0 and 1.
- R10: vblank_set sets the vblank pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Raster position is active this cycle |
| frame_start | input | 1 | Restarts the per-frame collision count |
| raster_x | input | 8 | Horizontal raster position |
| raster_y | input | 9 | Vertical raster position (bit 8 reported in status) |
| scroll_x | input | 8 | Background horizontal scroll |
| scroll_y | input | 8 | Background vertical scroll |
| bg_x | output | 8 | Scrolled background fetch X |
| bg_y | output | 8 | Scrolled background fetch Y |
| bg_pix | input | 3 | Background pixel at (bg_x, bg_y) |
| fg_pix | input | 3 | Foreground pixel at the raster position |
| narrow_mask | input | 1 | 1: only background bit 2 can collide |
| bg_irq_en | input | 1 | Lets background collisions drive irq |
| vblank_set | input | 1 | Sets vblank pending |
| clr_vblank | input | 1 | Clears vblank pending |
| fg_coll_set | input | 1 | Foreground collision event from the drawing engine |
| fg_coll_x | input | 8 | Foreground collision X |
| fg_coll_y | input | 8 | Foreground collision Y |
| busy | input | 1 | Drawing engine busy, reported in status |
| rd_en | input | 1 | Host read strobe (side effects at the clock edge) |
| rd_sel | input | 3 | Host read select |
| rd_data | output | 8 | Host read data |
| color_idx | output | 6 | Composed palette index |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that the colour index follows the previous cycle's pixels and that the collision count never passes its cap. They also check that the low bits of the background X read are zero, that a clearing read drops its flag unless a new event arrives, that a pending vblank always drives irq, and that the status bits mirror the pending flags. Some behaviour only the bench scenarios can show. These include the exact mask choice for each pixel combination, the wrap of the scrolled coordinates, and the latch holding the last counted position once the cap has been passed. They also include the count restarting after frame_start and the gating of the background flag by bg_irq_en.

// File: rtl/mix_pkg.sv
package mix_pkg;
    localparam int COORD_W = 8;
    localparam int PIX_W   = 3;

    typedef enum logic [2:0] {
        SEL_FG_X   = 3'd0,
        SEL_FG_Y   = 3'd1,
        SEL_BG_X   = 3'd2,
        SEL_BG_Y   = 3'd3,
        SEL_STATUS = 3'd4
    } rd_sel_e;

    typedef struct packed {
        logic               bg_pend;
        logic               fg_pend;
        logic               vb_pend;
        logic [COORD_W-1:0] fg_x;
        logic [COORD_W-1:0] fg_y;
    } flag_state_t;
endpackage

// File: rtl/mix_pixel_path.sv
module mix_pixel_path
    import mix_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] raster_x,
    input  logic [COORD_W-1:0] raster_y,
    input  logic [COORD_W-1:0] scroll_x,
    input  logic [COORD_W-1:0] scroll_y,
    input  logic [PIX_W-1:0]   bg_pix,
    input  logic [PIX_W-1:0]   fg_pix,
    input  logic               narrow_mask,
    output logic [COORD_W-1:0] bg_x,
    output logic [COORD_W-1:0] bg_y,
    output logic               hit,
    output logic [2*PIX_W-1:0] color_idx
);
    localparam logic [PIX_W-1:0] MASK_WIDE   = {PIX_W{1'b1}};
    localparam logic [PIX_W-1:0] MASK_NARROW = {1'b1, {(PIX_W-1){1'b0}}};

    logic [2*PIX_W-1:0] color_d, color_q;
    logic [PIX_W-1:0]   mask;

    always_comb begin
        bg_x    = raster_x + scroll_x;
        bg_y    = raster_y + scroll_y;
        mask    = narrow_mask ? MASK_NARROW : MASK_WIDE;
        hit     = pix_valid && (fg_pix != '0) && ((bg_pix & mask) != '0);
        color_d = color_q;
        if (pix_valid) color_d = {fg_pix, bg_pix};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) color_q <= '0;
        else        color_q <= color_d;
    end

    assign color_idx = color_q;
endmodule

// File: rtl/mix_coll_track.sv
module mix_coll_track
    import mix_pkg::*;
#(
    parameter int CAP = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               hit,
    input  logic [COORD_W-1:0] raster_x,
    input  logic [COORD_W-1:0] raster_y,
    output logic               take,
    output logic [CNT_W-1:0]   cnt,
    output logic [COORD_W-1:0] lat_x,
    output logic [COORD_W-1:0] lat_y
);
    localparam int CNT_W = $clog2(CAP + 1);
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

    logic [CNT_W-1:0]   cnt_d, cnt_q, base;
    logic [COORD_W-1:0] x_d, x_q, y_d, y_q;

    always_comb begin
        base  = frame_start ? '0 : cnt_q;
        take  = hit && (base < CAP_V);
        cnt_d = take ? base + 1'b1 : base;
        x_d   = take ? raster_x : x_q;
        y_d   = take ? raster_y : y_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
        end else begin
            cnt_q <= cnt_d;
            x_q   <= x_d;
            y_q   <= y_d;
        end
    end

    assign cnt   = cnt_q;
    assign lat_x = x_q;
    assign lat_y = y_q;
endmodule

// File: rtl/mix_irq_regs.sv
module mix_irq_regs
    import mix_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bg_take,
    input  logic [COORD_W-1:0] bg_lat_x,
    input  logic [COORD_W-1:0] bg_lat_y,
    input  logic               fg_set,
    input  logic [COORD_W-1:0] fg_x,
    input  logic [COORD_W-1:0] fg_y,
    input  logic               vb_set,
    input  logic               vb_clr,
    input  logic               bg_irq_en,
    input  logic               busy,
    input  logic               vpos_hi,
    input  logic               rd_en,
    input  logic [2:0]         rd_sel,
    output logic [7:0]         rd_data,
    output logic               irq,
    output logic               bg_pend,
    output logic               fg_pend,
    output logic               vb_pend
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en && rd_sel == SEL_BG_Y) st_d.bg_pend = 1'b0;
        if (bg_take)                     st_d.bg_pend = 1'b1;
        if (rd_en && rd_sel == SEL_FG_Y) st_d.fg_pend = 1'b0;
        if (fg_set) begin
            st_d.fg_pend = 1'b1;
            st_d.fg_x    = fg_x;
            st_d.fg_y    = fg_y;
        end
        if (vb_clr) st_d.vb_pend = 1'b0;
        if (vb_set) st_d.vb_pend = 1'b1;

        unique case (rd_sel)
            SEL_FG_X:   rd_data = st_q.fg_x;
            SEL_FG_Y:   rd_data = st_q.fg_y;
            SEL_BG_X:   rd_data = {bg_lat_x[7:2], 2'b00};
            SEL_BG_Y:   rd_data = bg_lat_y;
            SEL_STATUS: rd_data = {busy, ~st_q.fg_pend, ~st_q.vb_pend,
                                   ~st_q.bg_pend, vpos_hi, 3'b000};
            default:    rd_data = 8'h00;
        endcase

        irq = st_q.vb_pend | st_q.fg_pend | (st_q.bg_pend & bg_irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bg_pend = st_q.bg_pend;
    assign fg_pend = st_q.fg_pend;
    assign vb_pend = st_q.vb_pend;
endmodule

// File: rtl/layer_mixer.sv
module layer_mixer #(
    parameter int COLL_CAP = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_valid,
    input  logic       frame_start,
    input  logic [7:0] raster_x,
    input  logic [8:0] raster_y,
    input  logic [7:0] scroll_x,
    input  logic [7:0] scroll_y,
    output logic [7:0] bg_x,
    output logic [7:0] bg_y,
    input  logic [2:0] bg_pix,
    input  logic [2:0] fg_pix,
    input  logic       narrow_mask,
    input  logic       bg_irq_en,
    input  logic       vblank_set,
    input  logic       clr_vblank,
    input  logic       fg_coll_set,
    input  logic [7:0] fg_coll_x,
    input  logic [7:0] fg_coll_y,
    input  logic       busy,
    input  logic       rd_en,
    input  logic [2:0] rd_sel,
    output logic [7:0] rd_data,
    output logic [5:0] color_idx,
    output logic       irq
);
    localparam int CNT_W = $clog2(COLL_CAP + 1);

    logic             bg_hit, bg_take;
    logic [CNT_W-1:0] coll_cnt;
    logic [7:0]       bg_lat_x, bg_lat_y;
    logic             bg_pend, fg_pend, vb_pend;

    mix_pixel_path u_path (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .raster_x(raster_x), .raster_y(raster_y[7:0]),
        .scroll_x(scroll_x), .scroll_y(scroll_y),
        .bg_pix(bg_pix), .fg_pix(fg_pix), .narrow_mask(narrow_mask),
        .bg_x(bg_x), .bg_y(bg_y), .hit(bg_hit), .color_idx(color_idx)
    );

    mix_coll_track #(.CAP(COLL_CAP)) u_track (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .hit(bg_hit),
        .raster_x(raster_x), .raster_y(raster_y[7:0]),
        .take(bg_take), .cnt(coll_cnt), .lat_x(bg_lat_x), .lat_y(bg_lat_y)
    );

    mix_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bg_take(bg_take),
        .bg_lat_x(bg_lat_x), .bg_lat_y(bg_lat_y),
        .fg_set(fg_coll_set), .fg_x(fg_coll_x), .fg_y(fg_coll_y),
        .vb_set(vblank_set), .vb_clr(clr_vblank), .bg_irq_en(bg_irq_en),
        .busy(busy), .vpos_hi(raster_y[8]), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq),
        .bg_pend(bg_pend), .fg_pend(fg_pend), .vb_pend(vb_pend)
    );
endmodule

// File: rtl/mix_checker.sv
module mix_checker #(
    parameter int CAP   = 128,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [2:0]       fg_pix,
    input logic [2:0]       bg_pix,
    input logic [5:0]       color_idx,
    input logic             rd_en,
    input logic [2:0]       rd_sel,
    input logic [7:0]       rd_data,
    input logic             irq,
    input logic             vb_pend,
    input logic             bg_pend,
    input logic             bg_take,
    input logic [CNT_W-1:0] coll_cnt
);
    AST_COLOR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> color_idx == {$past(fg_pix), $past(bg_pix)}); // R2
    AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        coll_cnt <= CNT_W'(CAP)); // R4
    AST_BGX_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 3'd2) |-> rd_data[1:0] == 2'b00); // R7
    AST_BG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 3'd3 && !bg_take) |=> !bg_pend); // R6
    AST_VBLANK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        vb_pend |-> irq); // R5
    AST_STATUS_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 3'd4) |-> rd_data[5] == !vb_pend && rd_data[4] == !bg_pend); // R8
endmodule

bind layer_mixer mix_checker #(.CAP(COLL_CAP), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .fg_pix(fg_pix),
    .bg_pix(bg_pix), .color_idx(color_idx), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq), .vb_pend(vb_pend), .bg_pend(bg_pend),
    .bg_take(bg_take), .coll_cnt(coll_cnt)
);

// File: tb/test_layer_mixer.sv
`timescale 1ns/100ps
module test_layer_mixer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 0, frame_start = 0;
    logic [7:0] raster_x = 0;
    logic [8:0] raster_y = 0;
    logic [7:0] scroll_x = 0, scroll_y = 0;
    logic [7:0] bg_x, bg_y;
    logic [2:0] bg_pix = 0, fg_pix = 0;
    logic       narrow_mask = 0, bg_irq_en = 0;
    logic       vblank_set = 0, clr_vblank = 0, fg_coll_set = 0;
    logic [7:0] fg_coll_x = 0, fg_coll_y = 0;
    logic       busy = 0, rd_en = 0;
    logic [2:0] rd_sel = 0;
    logic [7:0] rd_data;
    logic [5:0] color_idx;
    logic       irq;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    layer_mixer i_layer_mixer (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
        .raster_x(raster_x), .raster_y(raster_y), .scroll_x(scroll_x), .scroll_y(scroll_y),
        .bg_x(bg_x), .bg_y(bg_y), .bg_pix(bg_pix), .fg_pix(fg_pix),
        .narrow_mask(narrow_mask), .bg_irq_en(bg_irq_en), .vblank_set(vblank_set),
        .clr_vblank(clr_vblank), .fg_coll_set(fg_coll_set), .fg_coll_x(fg_coll_x),
        .fg_coll_y(fg_coll_y), .busy(busy), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .color_idx(color_idx), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pixel(input logic [7:0] x, input logic [8:0] y,
                         input logic [2:0] fg, input logic [2:0] bg);
        @(negedge clk);
        raster_x = x; raster_y = y; fg_pix = fg; bg_pix = bg; pix_valid = 1;
        @(posedge clk); #1;
        pix_valid = 0;
    endtask

    task automatic host_read(input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        rd_sel = sel; rd_en = 1; #1;
        d = rd_data;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1;
        @(posedge clk); #1; frame_start = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R2 reset color", color_idx, 0);
        chk("R5 reset irq", irq, 0);
        host_read(3'd4, d);
        chk("R8 reset status", d, 8'h70);
        host_read(3'd2, d);
        chk("R7 reset bg x", d, 0);
    endtask

    task automatic t_coords();
        @(negedge clk);
        raster_x = 200; raster_y = 250; scroll_x = 100; scroll_y = 10; #1;
        chk("R1 wrap x", bg_x, 44);
        chk("R1 wrap y", bg_y, 4);
        scroll_x = 0; scroll_y = 3; raster_x = 7; raster_y = 9'h120; #1;
        chk("R1 plain x", bg_x, 7);
        chk("R1 y low byte", bg_y, 8'h23);
        scroll_y = 0;
    endtask

    task automatic t_color();
        pixel(8'd1, 9'd1, 3'd5, 3'd3);
        chk("R2 color 5/3", color_idx, 6'h2B);
        pixel(8'd2, 9'd1, 3'd0, 3'd7);
        chk("R2 color 0/7", color_idx, 6'h07);
        @(negedge clk); fg_pix = 3'd6; bg_pix = 3'd6; @(posedge clk); #1;
        chk("R2 hold when idle", color_idx, 6'h07);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        narrow_mask = 0;
        pixel(8'h37, 9'h51, 3'd1, 3'd2);
        host_read(3'd4, d);
        chk("R3 wide mask hit", d[4], 0);
        host_read(3'd2, d);
        chk("R4 latch x low bits dropped R7", d, 8'h34);
        host_read(3'd3, d);
        chk("R4 latch y", d, 8'h51);
        host_read(3'd4, d);
        chk("R6 bg read clears", d[4], 1);
        narrow_mask = 1;
        pixel(8'h40, 9'h10, 3'd2, 3'd3);
        host_read(3'd4, d);
        chk("R3 narrow mask no hit", d[4], 1);
        pixel(8'h44, 9'h11, 3'd0, 3'd4);
        host_read(3'd4, d);
        chk("R3 zero fg no hit", d[4], 1);
        pixel(8'h48, 9'h12, 3'd3, 3'd4);
        host_read(3'd4, d);
        chk("R3 narrow mask hit", d[4], 0);
        narrow_mask = 0;
    endtask

    task automatic t_irq_gate();
        logic [7:0] d;
        bg_irq_en = 0; #1;
        chk("R5 bg pend gated", irq, 0);
        bg_irq_en = 1; #1;
        chk("R5 bg pend enabled", irq, 1);
        host_read(3'd3, d);
        chk("R5 irq drops after clear R6", irq, 0);
        bg_irq_en = 0;
    endtask

    task automatic t_cap();
        logic [7:0] d;
        pulse_frame();
        for (int i = 0; i < 128; i++) pixel(8'(i), 9'd5, 3'd1, 3'd7);
        pixel(8'd200, 9'd6, 3'd1, 3'd7);
        pixel(8'd201, 9'd7, 3'd1, 3'd7);
        host_read(3'd2, d);
        chk("R4 cap keeps x", d, 8'h7C);
        host_read(3'd3, d);
        chk("R4 cap keeps y", d, 8'd5);
        pixel(8'd210, 9'd8, 3'd1, 3'd7);
        host_read(3'd4, d);
        chk("R4 capped no flag", d[4], 1);
        pulse_frame();
        pixel(8'h88, 9'h99, 3'd1, 3'd7);
        host_read(3'd2, d);
        chk("R4 new frame x", d, 8'h88);
        host_read(3'd3, d);
        chk("R4 new frame y", d, 8'h99);
    endtask

    task automatic t_fg();
        logic [7:0] d;
        @(negedge clk);
        fg_coll_set = 1; fg_coll_x = 8'hA5; fg_coll_y = 8'h3C;
        @(posedge clk); #1; fg_coll_set = 0;
        chk("R9 fg irq", irq, 1);
        host_read(3'd4, d);
        chk("R8 fg status", d[6], 0);
        host_read(3'd0, d);
        chk("R9 fg x", d, 8'hA5);
        chk("R6 fg x read no clear", irq, 1);
        @(negedge clk);
        rd_sel = 3'd1; rd_en = 1; fg_coll_set = 1; fg_coll_x = 8'h11;
        @(posedge clk); #1; rd_en = 0; fg_coll_set = 0;
        chk("R6 set wins over clear", irq, 1);
        host_read(3'd1, d);
        chk("R9 fg y", d, 8'h3C);
        chk("R6 fg y read clears", irq, 0);
        host_read(3'd6, d);
        chk("R7 unused code", d, 0);
    endtask

    task automatic t_vblank();
        logic [7:0] d;
        @(negedge clk); vblank_set = 1; @(posedge clk); #1; vblank_set = 0;
        chk("R10 vblank irq", irq, 1);
        host_read(3'd4, d);
        chk("R8 vblank status", d, 8'h50);
        @(negedge clk); clr_vblank = 1; @(posedge clk); #1; clr_vblank = 0;
        chk("R6 vblank cleared", irq, 0);
        @(negedge clk); busy = 1; raster_y = 9'h100;
        host_read(3'd4, d);
        chk("R8 busy and vpos", d, 8'hF8);
        busy = 0; raster_y = 0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_coords();
        t_color();
        t_mask();
        t_irq_gate();
        t_cap();
        t_fg();
        t_vblank();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule